// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an SPI host read and write a small file of 8-bit registers. SCL, chip select and the data inputs all pass through two-flop synchronizers, and every serial event is detected as an edge in the system clock domain. For that reason the system clock must run several times faster than SCL. SCL idles high while chip select is high. The host launches bits on the falling edge of SCL, and the slave samples them on the rising edge.

A frame begins with a command byte. Its first bit is the direction (1 read, 0 write), its second bit is the auto-increment flag, and the remaining six bits give the register address. One or more data bytes follow the command byte. Bit 0 of the interface-mode register selects between two wirings at run time: a separate data-out pin, or one shared data line with an output enable. Address 0x00 holds a fixed identification value. A range of addresses is reserved and cannot be written.

Top module: `spi_regs_slave`

## Requirements
- R1: SCL edges and data-line activity while chip select is high have no effect on any register or output.
- R2: The command byte is taken MSb first: bit 7 is the direction (1 read, 0 write), bit 6 is the increment flag and bits 5..0 are the address. Data bytes are also sent MSb first.
- R3: A write frame of 16 SCL pulses stores its data byte in the addressed register, and a later read of that address returns the byte.
- R4: On a read, the slave drives the first data bit on the SCL falling edge that starts frame bit 8. It keeps its output enabled through every data byte and shifts out MSb first.
- R5: Each extra group of 8 pulses moves one more byte. When the increment flag is 1, the address advances by one after every data byte and wraps from 0x3F to 0x00. When the flag is 0, the address stays fixed.
- R6: Address 0x00 always reads 0xDA, and writes to it have no effect.
- R7: Writes to addresses 0x11 through 0x1E are ignored, and reads from those addresses return 0x00.
- R8: Bit 0 of the register at address 0x20 selects the wiring. When it is 0, input comes on sdi_i and output goes to sdo_o/sdo_oe. When it is 1, input and output share sdio_i/sdio_o/sdio_oe and sdo_oe stays 0. The mode is shown on three_wire_o.
- R9: Both output enables are 0 during the command byte, during write frames and while chip select is high.
- R10: If chip select rises partway through a byte, that byte is discarded without a write, and the next frame starts again at bit 0.
- R11: After reset, both output enables are 0 and the port is in 4-wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in for 4-wire mode |
| sdio_i | input | 1 | Shared line, input side, for 3-wire mode |
| sdio_o | output | 1 | Shared line, output value |
| sdio_oe | output | 1 | Shared line output enable |
| sdo_o | output | 1 | Serial data out for 4-wire mode |
| sdo_oe | output | 1 | Output enable of sdo_o |
| three_wire_o | output | 1 | Current interface mode, 1 = shared line |

## Verification
Assertions check several properties on every cycle. They confirm that both output enables stay low once chip select is high, that the two enables are never both high, and that the bit counter is cleared after chip select rises. They also confirm that the identification and reserved addresses always return their fixed values, and that the mode flop changes only when a write occurs. Other properties depend on whole frames and can only be shown by the bench's scenarios. These are the stored contents after sweeps over all 64 addresses, increment and wrap-around in bursts, bursts that cross the reserved range, frames cut short, and correct data on the shared line after a switch of mode at run time.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic              rd;
    logic              inc;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int         W      = 1,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              cs_s,
  input  logic              din,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              tx_bit,
  output logic              tx_oe
);
  logic              scl_q;
  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] tx_sh;
  logic [ADDR_W-1:0] addr;
  logic              in_cmd, is_read, incr;
  logic              scl_rise, scl_fall, byte_done;
  logic [DATA_W-1:0] new_byte;
  cmd_t              cmd_w;
  logic [ADDR_W-1:0] addr_nxt;

  assign scl_rise  = scl_s & ~scl_q & ~cs_s;
  assign scl_fall  = ~scl_s & scl_q & ~cs_s;
  assign byte_done = scl_rise && (bit_cnt == BIT_W'(DATA_W-1));
  assign new_byte  = {shreg[DATA_W-2:0], din};
  assign cmd_w     = cmd_t'(new_byte);
  assign addr_nxt  = incr ? addr + 1'b1 : addr;

  always_ff @(posedge clk) begin
    if (rst) scl_q <= 1'b1;
    else     scl_q <= scl_s;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      bit_cnt <= '0;
      shreg   <= '0;
      in_cmd  <= 1'b1;
      is_read <= 1'b0;
      incr    <= 1'b0;
      tx_oe   <= 1'b0;
      tx_bit  <= 1'b0;
      rd_en   <= 1'b0;
      wr_en   <= 1'b0;
      if (rst) begin
        addr    <= '0;
        rd_addr <= '0;
        wr_addr <= '0;
        wr_data <= '0;
        tx_sh   <= '0;
      end
    end else begin
      rd_en <= 1'b0;
      wr_en <= 1'b0;
      if (scl_rise) begin
        shreg   <= new_byte;
        bit_cnt <= bit_cnt + 1'b1;
        if (byte_done) begin
          if (in_cmd) begin
            in_cmd  <= 1'b0;
            is_read <= cmd_w.rd;
            incr    <= cmd_w.inc;
            addr    <= cmd_w.addr;
            if (cmd_w.rd) begin
              rd_en   <= 1'b1;
              rd_addr <= cmd_w.addr;
            end
          end else if (is_read) begin
            addr    <= addr_nxt;
            rd_en   <= 1'b1;
            rd_addr <= addr_nxt;
          end else begin
            wr_en   <= 1'b1;
            wr_addr <= addr;
            wr_data <= new_byte;
            addr    <= addr_nxt;
          end
        end
      end
      if (scl_fall && !in_cmd && is_read) begin
        if (bit_cnt == '0) begin
          tx_sh  <= rd_data;
          tx_bit <= rd_data[DATA_W-1];
          tx_oe  <= 1'b1;
        end else begin
          tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
          tx_bit <= tx_sh[DATA_W-2];
        end
      end
    end
  end

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cs_s && $past(cs_s)) |-> !tx_oe);                              // R9
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_s) |=> (bit_cnt == '0 && in_cmd));                     // R10
  AST_DRIVE_AT_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_oe) |-> ($past(scl_fall) && $past(bit_cnt) == '0));    // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));                                             // R2
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE  = 8'hDA,
  parameter logic [ADDR_W-1:0] ID_ADDR   = 6'h00,
  parameter logic [ADDR_W-1:0] RSV_LO    = 6'h11,
  parameter logic [ADDR_W-1:0] RSV_HI    = 6'h1E,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 6'h20,
  parameter int                MODE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mode_q
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_ok;

  assign wr_ok = wr_en && (wr_addr != ID_ADDR) && !in_window(wr_addr, RSV_LO, RSV_HI);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_addr == ID_ADDR)                       rd_data <= ID_VALUE;
      else if (in_window(rd_addr, RSV_LO, RSV_HI)) rd_data <= '0;
      else                                          rd_data <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               mode_q <= 1'b0;
    else if (wr_ok && wr_addr == MODE_ADDR) mode_q <= wr_data[MODE_BIT];
  end

  AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ID_ADDR) |=> (rd_data == ID_VALUE));       // R6
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_window(rd_addr, RSV_LO, RSV_HI)) |=> (rd_data == '0)); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mode_q));                                    // R8
endmodule

// File: rtl/spi_regs_slave.sv
module spi_regs_slave
  import spi_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE    = 8'hDA,
  parameter logic [ADDR_W-1:0] RSV_LO      = 6'h11,
  parameter logic [ADDR_W-1:0] RSV_HI      = 6'h1E,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 6'h20,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe,
  output logic sdo_o,
  output logic sdo_oe,
  output logic three_wire_o
);
  logic [3:0]        sync_q;
  logic              scl_s, cs_s, sdi_s, sdio_s, din;
  logic              rd_en, wr_en, tx_bit, tx_oe, mode_q;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  spi_in_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, cs_n_i, sdi_i, sdio_i}), .q(sync_q));

  assign {scl_s, cs_s, sdi_s, sdio_s} = sync_q;
  assign din = mode_q ? sdio_s : sdi_s;

  spi_frame u_frame (
    .clk(clk), .rst(rst), .scl_s(scl_s), .cs_s(cs_s), .din(din),
    .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_bit(tx_bit), .tx_oe(tx_oe));

  spi_regfile #(.ID_VALUE(ID_VALUE), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI),
                .MODE_ADDR(MODE_ADDR)) u_regs (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .mode_q(mode_q));

  assign sdo_o        = tx_bit;
  assign sdo_oe       = tx_oe & ~mode_q;
  assign sdio_o       = tx_bit;
  assign sdio_oe      = tx_oe & mode_q;
  assign three_wire_o = mode_q;

  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    !(sdo_oe && sdio_oe));                                          // R8
endmodule

// File: tb/tb_spi_regs_slave.sv
module tb_spi_regs_slave;
  localparam int HALF = 6;
  localparam logic [5:0] MODE_A = 6'h20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_i = 1'b1, cs_n_i = 1'b1, sdi_i = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe, three_wire_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit mode3 = 1'b0;
  bit oe_bad;
  logic [7:0] model [64];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #10 clk = ~clk;

  spi_regs_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl_i), .cs_n_i(cs_n_i), .sdi_i(sdi_i),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o),
    .sdo_oe(sdo_oe), .three_wire_o(three_wire_o));

  function automatic bit writable(input logic [5:0] a);
    return (a != 6'h00) && !(a >= 6'h11 && a <= 6'h1E);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, input int nbits, input bit drive,
                          output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      scl_i = 1'b0;
      if (mode3) begin sdio_i = tx[7-i]; sdi_i = ~tx[7-i]; end
      else       begin sdi_i = tx[7-i]; sdio_i = ~tx[7-i]; end
      repeat (HALF) @(negedge clk);
      rx = {rx[6:0], (mode3 ? sdio_o : sdo_o)};
      if (mode3 ? (sdio_oe !== drive || sdo_oe !== 1'b0)
                : (sdo_oe !== drive || sdio_oe !== 1'b0)) oe_bad = 1'b1;
      scl_i = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic spi_frame(input bit rd, input bit inc, input logic [5:0] a, input int nb);
    logic [7:0] dummy;
    logic [5:0] cur;
    bit new_mode;
    oe_bad = 1'b0;
    new_mode = mode3;
    cur = a;
    cs_n_i = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_byte({rd, inc, a}, 8, 1'b0, dummy);
    for (int k = 0; k < nb; k++) begin
      spi_byte(wbuf[k], 8, rd, rbuf[k]);
      if (!rd && writable(cur)) begin
        model[cur] = wbuf[k];
        if (cur == MODE_A) new_mode = wbuf[k][0];
      end
      if (inc) cur = cur + 1'b1;
    end
    cs_n_i = 1'b1;
    repeat (2*HALF) @(negedge clk);
    mode3 = new_mode;
    chk("R9 R4 output enable pattern", {31'd0, oe_bad}, 32'd0);
  endtask

  task automatic read_check(input bit inc, input logic [5:0] a, input int nb, input string tag);
    logic [5:0] cur;
    cur = a;
    spi_frame(1'b1, inc, a, nb);
    for (int k = 0; k < nb; k++) begin
      chk($sformatf("%s addr=%0h", tag, cur), rbuf[k], model[cur]);
      if (inc) cur = cur + 1'b1;
    end
  endtask

  initial begin
    for (int a = 0; a < 64; a++) model[a] = 8'h00;
    model[0] = 8'hDA;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset sdo_oe", {31'd0, sdo_oe}, 32'd0);
    chk("R11 reset sdio_oe", {31'd0, sdio_oe}, 32'd0);
    chk("R11 reset mode", {31'd0, three_wire_o}, 32'd0);

    // single-byte sweep over every address
    for (int a = 0; a < 64; a++) begin
      wbuf[0] = 8'((a * 37 + 5) & 255);
      if (a == MODE_A) wbuf[0][0] = 1'b0;
      spi_frame(1'b0, 1'b0, 6'(a), 1);
    end
    for (int a = 0; a < 64; a++) begin
      if (a == 0)                 read_check(1'b0, 6'(a), 1, "R6 id register");
      else if (a >= 17 && a <= 30) read_check(1'b0, 6'(a), 1, "R7 reserved");
      else                        read_check(1'b0, 6'(a), 1, "R2_R3 single access");
    end

    // R1: clocks with chip select high
    for (int i = 0; i < 12; i++) begin
      scl_i = 1'b0; sdi_i = i[0]; sdio_i = i[1];
      repeat (HALF) @(negedge clk);
      scl_i = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    chk("R1 idle outputs", {30'd0, sdo_oe, sdio_oe}, 32'd0);
    read_check(1'b1, 6'h08, 4, "R1 no change while deselected");

    // R5: incrementing and fixed bursts
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    spi_frame(1'b0, 1'b1, 6'h08, 4);
    read_check(1'b1, 6'h08, 4, "R5 increment burst");
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    spi_frame(1'b0, 1'b1, 6'h10, 3);
    read_check(1'b1, 6'h0F, 4, "R7 R5 burst into reserved");
    wbuf[0] = 8'h61; wbuf[1] = 8'h62; wbuf[2] = 8'h63;
    spi_frame(1'b0, 1'b0, 6'h05, 3);
    read_check(1'b0, 6'h05, 2, "R5 fixed address burst");
    read_check(1'b1, 6'h04, 3, "R5 neighbours untouched");
    wbuf[0] = 8'h7E; wbuf[1] = 8'h99;
    spi_frame(1'b0, 1'b1, 6'h3F, 2);
    read_check(1'b1, 6'h3F, 2, "R5 R6 wrap to id");

    // R10: frame cut partway through the data byte
    oe_bad = 1'b0;
    cs_n_i = 1'b0;
    repeat (HALF) @(negedge clk);
    begin
      logic [7:0] d;
      spi_byte({1'b0, 1'b0, 6'h07}, 8, 1'b0, d);
      spi_byte(8'h55, 5, 1'b0, d);
    end
    cs_n_i = 1'b1;
    repeat (2*HALF) @(negedge clk);
    chk("R10 no drive on aborted write", {31'd0, oe_bad}, 32'd0);
    read_check(1'b0, 6'h07, 1, "R10 partial byte discarded");
    // command cut short
    cs_n_i = 1'b0;
    repeat (HALF) @(negedge clk);
    begin
      logic [7:0] d;
      spi_byte(8'hC3, 3, 1'b0, d);
    end
    cs_n_i = 1'b1;
    repeat (2*HALF) @(negedge clk);
    read_check(1'b1, 6'h06, 2, "R10 counter restarts");

    // R8: switch to the shared line and back
    wbuf[0] = 8'h01;
    spi_frame(1'b0, 1'b0, MODE_A, 1);
    chk("R8 mode now shared", {31'd0, three_wire_o}, 32'd1);
    wbuf[0] = 8'h3C;
    spi_frame(1'b0, 1'b0, 6'h09, 1);
    read_check(1'b0, 6'h09, 1, "R8 shared line readback");
    read_check(1'b1, 6'h1F, 3, "R8 shared line burst");
    read_check(1'b0, 6'h00, 1, "R8 R6 id on shared line");
    wbuf[0] = 8'h02;
    spi_frame(1'b0, 1'b0, MODE_A, 1);
    chk("R8 mode back to separate", {31'd0, three_wire_o}, 32'd0);
    read_check(1'b1, 6'h08, 3, "R8 separate line readback");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule